// File: doc/BRIEF.md
# DMA and CPU Shared-Memory Arbiter

This block places one main-memory port between two masters: a CPU and a single-channel DMA engine that moves words between one device and memory. Only one master can use the port in a given cycle. The choice between them follows one of three sharing policies, selected at run time:

- **Halt**: the whole transfer belongs to the DMA side.
- **Cycle stealing**: the device takes a cycle only when it has a word to move.
- **Fixed slots**: the cycles alternate between a CPU slot and a DMA slot.

The block also runs the life of a DMA job. The job moves through these states and transitions:

- **PH_IDLE**: no job is running. `job_start` moves the block to PH_SETUP and latches the start address, word count and direction.
- **PH_SETUP**: lasts one cycle. With a zero count it goes straight to PH_DONE; otherwise it goes to PH_XFER.
- **PH_XFER**: each DMA grant moves one word. The grant that moves the last word leads to PH_DONE.
- **PH_DONE**: lasts one cycle. It sets a sticky interrupt flag and returns to PH_IDLE.

Grants and the memory port are decided combinationally within the same cycle. The memory is expected to return read data combinationally on `mem_rdata`.

Top module: `dma_mem_arbiter`

## Requirements
- R1: Reset forces PH_IDLE, clears `done_irq`, selects the halt policy and makes the first cycle after reset a CPU slot.
- R2: At most one of `cpu_gnt` and `dev_gnt` is high in a cycle. `mem_en` equals their OR. The port carries the granted master's address, write enable and write data.
- R3: `mode_sel` uses these codes: 0 = halt, 1 = cycle stealing, 2 = fixed slots, 3 = cycle stealing. The code is registered only in PH_IDLE and applies from the next cycle. A change during a job has no effect until the block is back in PH_IDLE.
- R4: `job_start` is accepted only in PH_IDLE. A job then takes exactly one PH_SETUP cycle, a PH_XFER phase and exactly one PH_DONE cycle, and returns to PH_IDLE. `job_start` is ignored in every other state.
- R5: Each DMA grant raises the job address by one, wrapping modulo 2^AW, and lowers the count by one. The job makes exactly `job_count` grants. A count of 0 goes from PH_SETUP directly to PH_DONE with no grant.
- R6: `done_irq` rises at the edge that leaves PH_DONE. It stays high until `irq_clr` is sampled high, and setting it wins over clearing it.
- R7: Halt policy: in PH_XFER the CPU is never granted, even in cycles where the device does not request. `dev_req` is granted every cycle it is high.
- R8: Cycle-stealing policy: in PH_XFER a high `dev_req` wins that cycle. The CPU is granted in every other cycle in which it requests.
- R9: Fixed-slot policy: slots alternate every cycle. The CPU may use only CPU slots and the device only DMA slots. An unused slot is not given to the other master.
- R10: Job direction 1 writes `dev_wdata` into memory at the job address. Direction 0 reads memory at the job address and presents the word on `dev_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Sharing policy code |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU write enable |
| cpu_addr | input | AW | CPU address |
| cpu_wdata | input | DW | CPU write data |
| cpu_gnt | output | 1 | CPU owns the port this cycle |
| cpu_rdata | output | DW | Read data to CPU |
| job_start | input | 1 | Begin a DMA job |
| job_addr | input | AW | Job start address |
| job_count | input | CW | Words in the job |
| job_dir | input | 1 | 1 = device to memory, 0 = memory to device |
| dev_req | input | 1 | Device has a word to move |
| dev_wdata | input | DW | Word from device |
| dev_gnt | output | 1 | DMA owns the port this cycle |
| dev_rdata | output | DW | Word to device |
| done_irq | output | 1 | Sticky completion flag |
| irq_clr | input | 1 | Clears `done_irq` |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |

## Verification
Grants, the memory port fields and both read-data outputs are valid in the same cycle as the request. The phase, the address, the count, the slot and the registered policy change at the next rising edge. `done_irq` appears three edges after an accepted `job_start` when the count is zero. The bench drives inputs just after a rising edge and compares every output at the falling edge against a behavioural model. It commits the model's next state only after the following rising edge, so each check looks at the cycle in which the result is due.

// File: rtl/dma_arb_pkg.sv
`timescale 1ns/1ps
package dma_arb_pkg;
    typedef enum logic [1:0] {
        POL_HALT  = 2'd0,
        POL_STEAL = 2'd1,
        POL_SLOT  = 2'd2,
        POL_RSVD  = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_XFER  = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;
endpackage

// File: rtl/dma_job_seq.sv
`timescale 1ns/1ps
module dma_job_seq
    import dma_arb_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          job_start,
    input  logic [AW-1:0] job_addr,
    input  logic [CW-1:0] job_count,
    input  logic          job_dir,
    input  logic          dma_gnt,
    input  logic          irq_clr,
    output phase_e        phase,
    output logic [AW-1:0] cur_addr,
    output logic          cur_dir,
    output logic          done_irq
);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);
    localparam logic [AW-1:0] ADDR_ONE = AW'(1);

    phase_e        phase_q, phase_d;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic          dir_q;
    logic          irq_q;

    // next-state logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:  if (job_start) phase_d = PH_SETUP;
            PH_SETUP: phase_d = (cnt_q == '0) ? PH_DONE : PH_XFER;
            PH_XFER:  if (dma_gnt && cnt_q == CNT_ONE) phase_d = PH_DONE;
            PH_DONE:  phase_d = PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // job registers and flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            dir_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (phase_q == PH_IDLE && job_start) begin
                addr_q <= job_addr;
                cnt_q  <= job_count;
                dir_q  <= job_dir;
            end else if (phase_q == PH_XFER && dma_gnt) begin
                addr_q <= addr_q + ADDR_ONE;
                cnt_q  <= cnt_q - CNT_ONE;
            end
            if (phase_q == PH_DONE) irq_q <= 1'b1;
            else if (irq_clr)       irq_q <= 1'b0;
        end
    end

    assign phase    = phase_q;
    assign cur_addr = addr_q;
    assign cur_dir  = dir_q;
    assign done_irq = irq_q;

    assert_gnt_only_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_gnt |-> phase_q == PH_XFER);
    assert_setup_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_SETUP |=> phase_q != PH_SETUP);
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_XFER && dma_gnt) |=> cnt_q == $past(cnt_q) - CNT_ONE);
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_XFER && dma_gnt) |=> addr_q == $past(addr_q) + ADDR_ONE);
    assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_DONE |=> irq_q);
    assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr) |=> irq_q);
endmodule

// File: rtl/dma_share_arb.sv
`timescale 1ns/1ps
module dma_share_arb
    import dma_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  phase_e     phase,
    input  logic       cpu_req,
    input  logic       dev_req,
    output logic       cpu_gnt,
    output logic       dma_gnt
);
    policy_e mode_q;
    logic    slot_q;   // 0 = CPU slot, 1 = DMA slot
    logic    in_xfer;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= POL_HALT;
            slot_q <= 1'b0;
        end else begin
            slot_q <= ~slot_q;
            if (phase == PH_IDLE) mode_q <= policy_e'(mode_sel);
        end
    end

    assign in_xfer = (phase == PH_XFER);

    always_comb begin
        cpu_gnt = 1'b0;
        dma_gnt = 1'b0;
        unique case (mode_q)
            POL_HALT: begin
                dma_gnt = in_xfer && dev_req;
                cpu_gnt = cpu_req && !in_xfer;
            end
            POL_SLOT: begin
                dma_gnt = in_xfer && dev_req && slot_q;
                cpu_gnt = cpu_req && !slot_q;
            end
            POL_STEAL, POL_RSVD: begin
                dma_gnt = in_xfer && dev_req;
                cpu_gnt = cpu_req && !(in_xfer && dev_req);
            end
            default: begin
                dma_gnt = 1'b0;
                cpu_gnt = 1'b0;
            end
        endcase
    end

    assert_one_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_gnt && dma_gnt));
    assert_mode_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phase != PH_IDLE |=> $stable(mode_q));
    assert_halt_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == POL_HALT && in_xfer) |-> !cpu_gnt);
    assert_steal_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == POL_STEAL && in_xfer && dev_req) |-> (dma_gnt && !cpu_gnt));
    assert_slot_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> slot_q != $past(slot_q));
    assert_slot_cpu_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == POL_SLOT && phase != PH_IDLE && cpu_gnt) |=> !cpu_gnt);
    assert_slot_dma_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == POL_SLOT && dma_gnt) |=> !dma_gnt);
endmodule

// File: rtl/dma_mem_mux.sv
`timescale 1ns/1ps
module dma_mem_mux #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          cpu_gnt,
    input  logic          dma_gnt,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic [AW-1:0] dma_addr,
    input  logic          dma_dir,
    input  logic [DW-1:0] dev_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic [DW-1:0] dev_rdata
);
    always_comb begin
        mem_en = cpu_gnt | dma_gnt;
        if (dma_gnt) begin
            mem_we    = dma_dir;
            mem_addr  = dma_addr;
            mem_wdata = dev_wdata;
        end else begin
            mem_we    = cpu_gnt & cpu_we;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
        end
    end

    assign cpu_rdata = mem_rdata;
    assign dev_rdata = mem_rdata;
endmodule

// File: rtl/dma_mem_arbiter.sv
`timescale 1ns/1ps
module dma_mem_arbiter
    import dma_arb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_gnt,
    output logic [DW-1:0] cpu_rdata,
    input  logic          job_start,
    input  logic [AW-1:0] job_addr,
    input  logic [CW-1:0] job_count,
    input  logic          job_dir,
    input  logic          dev_req,
    input  logic [DW-1:0] dev_wdata,
    output logic          dev_gnt,
    output logic [DW-1:0] dev_rdata,
    output logic          done_irq,
    input  logic          irq_clr,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    phase_e        phase;
    logic [AW-1:0] cur_addr;
    logic          cur_dir;
    logic          dma_gnt;

    dma_job_seq #(.AW(AW), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .job_start(job_start), .job_addr(job_addr),
        .job_count(job_count), .job_dir(job_dir),
        .dma_gnt(dma_gnt), .irq_clr(irq_clr),
        .phase(phase), .cur_addr(cur_addr),
        .cur_dir(cur_dir), .done_irq(done_irq)
    );

    dma_share_arb u_arb (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .phase(phase), .cpu_req(cpu_req), .dev_req(dev_req),
        .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt)
    );

    dma_mem_mux #(.AW(AW), .DW(DW)) u_mux (
        .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .dma_addr(cur_addr), .dma_dir(cur_dir), .dev_wdata(dev_wdata),
        .mem_rdata(mem_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .cpu_rdata(cpu_rdata), .dev_rdata(dev_rdata)
    );

    assign dev_gnt = dma_gnt;

    assert_port_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en == (cpu_gnt || dev_gnt));
    assert_no_cpu_write_when_dma_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_gnt && mem_we) |-> mem_wdata == dev_wdata);
endmodule

// File: tb/dma_mem_arbiter_tb.sv
`timescale 1ns/1ps
module dma_mem_arbiter_tb;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_gnt;
    logic [DW-1:0] cpu_rdata;
    logic job_start = 1'b0;
    logic [AW-1:0] job_addr = '0;
    logic [CW-1:0] job_count = '0;
    logic job_dir = 1'b0;
    logic dev_req = 1'b0;
    logic [DW-1:0] dev_wdata = '0;
    logic dev_gnt;
    logic [DW-1:0] dev_rdata;
    logic done_irq;
    logic irq_clr = 1'b0;
    logic mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    logic [DW-1:0] ram [0:NW-1];
    logic [DW-1:0] exp_mem [0:NW-1];

    int total = 0, bad = 0;
    bit finished = 0;
    string tag = "R1";

    // model state
    int m_ph = 0, m_mode = 0, m_slot = 0, m_irq = 0, m_dir = 0, m_cnt = 0;
    logic [AW-1:0] m_addr = '0;
    int xfer_cpu = 0, xfer_dev = 0, wcount = 0;

    dma_mem_arbiter #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_gnt(cpu_gnt), .cpu_rdata(cpu_rdata),
        .job_start(job_start), .job_addr(job_addr), .job_count(job_count),
        .job_dir(job_dir), .dev_req(dev_req), .dev_wdata(dev_wdata),
        .dev_gnt(dev_gnt), .dev_rdata(dev_rdata), .done_irq(done_irq),
        .irq_clr(irq_clr), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #2.5 clk = ~clk;

    assign mem_rdata = ram[mem_addr];
    always @(posedge clk) if (mem_en && mem_we) ram[mem_addr] <= mem_wdata;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // one clock: compare at falling edge, advance model after rising edge
    task automatic step();
        bit xf, cg, dg, ewe;
        logic [AW-1:0] ea;
        logic [DW-1:0] ewd;
        int n_ph, n_mode, n_irq, n_dir, n_cnt;
        logic [AW-1:0] n_addr;
        @(negedge clk);
        xf = (m_ph == 2);
        case (m_mode)
            0: begin dg = xf && dev_req; cg = cpu_req && !xf; end
            2: begin dg = xf && dev_req && m_slot == 1; cg = cpu_req && m_slot == 0; end
            default: begin dg = xf && dev_req; cg = cpu_req && !dg; end
        endcase
        chk(cpu_gnt === cg, tag, "cpu_gnt", cpu_gnt, cg);
        chk(dev_gnt === dg, tag, "dev_gnt", dev_gnt, dg);
        chk(mem_en === (cg | dg), "R2", "mem_en", mem_en, cg | dg);
        ea = dg ? m_addr : cpu_addr;
        ewe = dg ? (m_dir == 1) : cpu_we;
        ewd = dg ? dev_wdata : cpu_wdata;
        if (cg | dg) begin
            chk(mem_addr === ea, "R2", "mem_addr", mem_addr, ea);
            chk(mem_we === ewe, "R2", "mem_we", mem_we, ewe);
            if (ewe) chk(mem_wdata === ewd, "R2", "mem_wdata", mem_wdata, ewd);
        end
        if (dg && m_dir == 0) chk(dev_rdata === exp_mem[m_addr], "R10", "dev_rdata", dev_rdata, exp_mem[m_addr]);
        if (cg && !cpu_we) chk(cpu_rdata === exp_mem[cpu_addr], "R2", "cpu_rdata", cpu_rdata, exp_mem[cpu_addr]);
        chk(done_irq === (m_irq == 1), "R6", "done_irq", done_irq, m_irq);
        if (xf && cg) xfer_cpu++;
        if (dg) xfer_dev++;
        // next model state
        n_ph = m_ph; n_mode = m_mode; n_addr = m_addr; n_cnt = m_cnt; n_dir = m_dir;
        n_irq = (m_ph == 3) ? 1 : (irq_clr ? 0 : m_irq);
        case (m_ph)
            0: begin
                n_mode = mode_sel;
                if (job_start) begin
                    n_ph = 1; n_addr = job_addr; n_cnt = job_count; n_dir = job_dir;
                end
            end
            1: n_ph = (m_cnt == 0) ? 3 : 2;
            2: if (dg) begin
                n_addr = m_addr + 1'b1; n_cnt = m_cnt - 1;
                if (m_cnt == 1) n_ph = 3;
            end
            default: n_ph = 0;
        endcase
        @(posedge clk);
        #1;
        if ((cg | dg) && ewe) exp_mem[ea] = ewd;
        m_ph = n_ph; m_mode = n_mode; m_addr = n_addr; m_cnt = n_cnt;
        m_dir = n_dir; m_irq = n_irq; m_slot = 1 - m_slot;
        if (dg) begin wcount++; dev_wdata = 16'hA000 + 16'(wcount); end
        cpu_wdata = cpu_wdata + 16'h0011;
    endtask

    task automatic start_job(input logic [AW-1:0] a, input int n, input bit d);
        job_addr = a; job_count = CW'(n); job_dir = d; job_start = 1'b1;
        step();
        job_start = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        step();
        irq_clr = 1'b0;
        step();
        chk(done_irq === 1'b0, "R6", "irq after clear", done_irq, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) begin
            ram[i] = 16'h1000 + 16'(i * 7);
            exp_mem[i] = 16'h1000 + 16'(i * 7);
        end
        cpu_req = 1'b1; cpu_addr = 8'h40;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(done_irq === 1'b0, "R1", "irq in reset", done_irq, 0);
        chk(dev_gnt === 1'b0, "R1", "dev_gnt in reset", dev_gnt, 0);
        chk(cpu_gnt === 1'b1, "R1", "cpu_gnt halt idle", cpu_gnt, 1);
        @(posedge clk);
        #1 rst_n = 1'b1;
        dev_wdata = 16'hA000;

        // R7: halt policy, device writes with gaps
        tag = "R7"; mode_sel = 2'd0;
        repeat (3) step();
        start_job(8'h10, 4, 1'b1);
        for (int i = 0; i < 60 && !(m_ph == 0 && m_irq == 1); i++) begin
            dev_req = (i % 3 != 0);
            step();
        end
        dev_req = 1'b0;
        chk(done_irq === 1'b1, "R6", "irq after halt job", done_irq, 1);
        clear_irq();

        // R8: cycle stealing, device reads; R4: stray start ignored
        tag = "R8"; mode_sel = 2'd1; cpu_we = 1'b1; cpu_addr = 8'h50;
        step();
        start_job(8'h10, 3, 1'b0);
        for (int i = 0; i < 60 && !(m_ph == 0 && m_irq == 1); i++) begin
            dev_req = (i % 2 == 1);
            job_start = (i == 2); job_addr = 8'h80; job_count = 8'd9;
            step();
        end
        job_start = 1'b0; dev_req = 1'b0;
        chk(ram[8'h80] === exp_mem[8'h80], "R4", "stray start address untouched", ram[8'h80], exp_mem[8'h80]);
        clear_irq();

        // R9: fixed slots; R3: mode change during job ignored
        tag = "R9"; mode_sel = 2'd2; cpu_we = 1'b0; cpu_addr = 8'h50;
        step();
        xfer_cpu = 0; xfer_dev = 0;
        start_job(8'h30, 5, 1'b1);
        for (int i = 0; i < 60 && !(m_ph == 0 && m_irq == 1); i++) begin
            dev_req = 1'b1;
            if (i == 3) mode_sel = 2'd0;
            step();
        end
        dev_req = 1'b0;
        chk(xfer_cpu > 0, "R3", "cpu grants in transfer after mode change", xfer_cpu, 1);
        chk(xfer_dev == 5, "R5", "dev grants per job", xfer_dev, 5);
        clear_irq();

        // R5: zero-length job
        tag = "R5"; mode_sel = 2'd1;
        step();
        xfer_dev = 0;
        start_job(8'h60, 0, 1'b1);
        step(); step();
        chk(done_irq === 1'b1, "R5", "zero job irq after 3 edges", done_irq, 1);
        chk(xfer_dev == 0, "R5", "zero job grants", xfer_dev, 0);
        clear_irq();

        // R5: address wrap, reserved code 3 acting as stealing
        tag = "R3"; mode_sel = 2'd3; cpu_we = 1'b1; cpu_addr = 8'h70;
        step();
        start_job(8'hFE, 3, 1'b1);
        for (int i = 0; i < 60 && !(m_ph == 0 && m_irq == 1); i++) begin
            dev_req = 1'b1;
            step();
        end
        dev_req = 1'b0;
        chk(ram[8'h00] === exp_mem[8'h00], "R5", "wrapped word", ram[8'h00], exp_mem[8'h00]);
        clear_irq();
        cpu_req = 1'b0;
        step();

        // R10: final memory image
        for (int i = 0; i < NW; i++)
            chk(ram[i] === exp_mem[i], "R10", $sformatf("mem[%0h]", i), ram[i], exp_mem[i]);

        finished = 1;
        summary();
        $finish;
    end
endmodule